// File: doc/BRIEF.md
# DRAM Power-Up Wake Sequencer

This block brings an asynchronous DRAM from power-on to a usable state. After reset it keeps both row and column strobes inactive for a settling interval. The length of that interval is given in microseconds and converted to clock cycles from a clock-frequency parameter. When the interval ends, the block runs a burst of dummy wake cycles on the strobes and then raises a ready flag.

The burst takes one of two forms, picked by a mode input. In the first form each cycle pulses only the row strobe. In the second form the column strobe falls before the row strobe in each cycle, so that a device running on its internal refresh counter is woken properly.

While ready is high the block watches for strobe inactivity. When the strobes have been quiet for longer than an idle limit (also given in microseconds), the block treats the memory as having lost its wake state. It drops ready and runs a fresh burst with no settling pause in front of it.

Top module: `dram_wake_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, the outputs settle to ras_n=1, cas_n=1, busy=1 and ready=0.
- R2: After reset is released, both strobes stay high for exactly PAUSE_CYC = ceil(CLK_HZ*PAUSE_US/1e6) cycles before the first strobe falls.
- R3: A burst has exactly NWAKE wake cycles (NWAKE row-strobe falls), and ready rises only after the last of them.
- R4: In row-only form (mode bit 0), each wake cycle holds ras_n=0, cas_n=1 for T_ACT cycles and then holds both strobes high for T_PRE cycles.
- R5: In column-first form (mode bit 1), each wake cycle is: cas_n low alone for 1 cycle, both low for T_ACT cycles, ras_n high with cas_n still low for 1 cycle, then both high for T_PRE cycles.
- R6: The mode input is sampled once, in the cycle a burst starts. A change of mode during a burst has no effect until the next burst.
- R7: busy is the inverse of ready at all times. ready is low during the pause and every burst, and while ready is high both strobes are high.
- R8: ready stays high for exactly IDLE_CYC = ceil(CLK_HZ*IDLE_US/1e6) cycles. A new burst then starts in the next cycle, with no settling pause.
- R9: Reset asserted in the middle of a burst abandons it, and the full settling pause is repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cbr_mode | input | 1 | 1 selects column-first wake cycles, 0 selects row-only |
| ras_n | output | 1 | Row strobe, active low, registered |
| cas_n | output | 1 | Column strobe, active low, registered |
| busy | output | 1 | High during the pause and any wake burst |
| ready | output | 1 | High when the memory may be used |

## Verification
The bench run-length-encodes the four outputs and compares every segment's value and length against an expected list, so an off-by-one pause, an off-by-one phase, or a burst with seven or nine cycles shows up as a wrong segment length or an extra segment. A sequencer that re-read the mode pin during a burst would switch to row-only cycles partway through, and the bench catches this as a row-low segment with cas_n high. A design that inserted the settling pause before an idle re-burst would give a long all-high segment where a strobe fall is expected. A design that did not restart its timers on a mid-burst reset would produce a short pause after the second reset.

// File: rtl/dram_wake_seq.sv
module dram_wake_seq #(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned PAUSE_US = 200,
  parameter int unsigned IDLE_US  = 8000,
  parameter int unsigned NWAKE    = 8,
  parameter int unsigned T_ACT    = 5,
  parameter int unsigned T_PRE    = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic cbr_mode,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic ready
);
  localparam longint unsigned PAUSE_L = (64'(CLK_HZ) * 64'(PAUSE_US) + 64'd999_999) / 64'd1_000_000;
  localparam longint unsigned IDLE_L  = (64'(CLK_HZ) * 64'(IDLE_US)  + 64'd999_999) / 64'd1_000_000;
  localparam int unsigned PAUSE_CYC = (PAUSE_L < 1) ? 1 : int'(PAUSE_L);
  localparam int unsigned IDLE_CYC  = (IDLE_L  < 1) ? 1 : int'(IDLE_L);
  localparam int unsigned TMAX_A = (PAUSE_CYC > IDLE_CYC) ? PAUSE_CYC : IDLE_CYC;
  localparam int unsigned TMAX_B = (T_ACT > T_PRE) ? T_ACT : T_PRE;
  localparam int unsigned TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int unsigned TW = $clog2(TMAX + 1);
  localparam int unsigned NW = $clog2(NWAKE + 1);

  typedef enum logic [2:0] {S_PAUSE, S_LEAD, S_ACT, S_TAIL, S_PRE, S_READY} st_t;

  st_t           st, nxt, first;
  logic [TW-1:0] tmr, lim;
  logic [NW-1:0] ncyc;
  logic          cbr_q, cbr_nx, last, start;

  always_comb begin
    case (st)
      S_PAUSE: lim = TW'(PAUSE_CYC);
      S_ACT:   lim = TW'(T_ACT);
      S_PRE:   lim = TW'(T_PRE);
      S_READY: lim = TW'(IDLE_CYC);
      default: lim = TW'(1);
    endcase
  end

  assign last   = (tmr == lim - TW'(1));
  assign start  = last && (st == S_PAUSE || st == S_READY);
  assign cbr_nx = start ? cbr_mode : cbr_q;
  assign first  = cbr_nx ? S_LEAD : S_ACT;

  always_comb begin
    nxt = st;
    if (last) begin
      case (st)
        S_PAUSE: nxt = first;
        S_LEAD:  nxt = S_ACT;
        S_ACT:   nxt = cbr_q ? S_TAIL : S_PRE;
        S_TAIL:  nxt = S_PRE;
        S_PRE:   nxt = (ncyc == NW'(NWAKE - 1)) ? S_READY : first;
        S_READY: nxt = first;
        default: nxt = S_PAUSE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_PAUSE;
      tmr   <= '0;
      ncyc  <= '0;
      cbr_q <= 1'b0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      busy  <= 1'b1;
      ready <= 1'b0;
    end else begin
      st    <= nxt;
      tmr   <= last ? '0 : tmr + TW'(1);
      cbr_q <= cbr_nx;
      if (st == S_PRE && last)
        ncyc <= (ncyc == NW'(NWAKE - 1)) ? '0 : ncyc + NW'(1);
      ras_n <= (nxt != S_ACT);
      cas_n <= !(cbr_nx && (nxt == S_LEAD || nxt == S_ACT || nxt == S_TAIL));
      busy  <= (nxt != S_READY);
      ready <= (nxt == S_READY);
    end
  end

  // Checker state, separate from the control path
  logic          rst_d, ras_d;
  logic [TW-1:0] quiet_cnt, rdy_run;
  logic [NW:0]   nfall;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    ras_d <= ras_n;
    if (rst) begin
      quiet_cnt <= '0;
      rdy_run   <= '0;
      nfall     <= '0;
    end else begin
      if (quiet_cnt < TW'(PAUSE_CYC)) quiet_cnt <= quiet_cnt + TW'(1);
      rdy_run <= ready ? rdy_run + TW'(1) : '0;
      nfall   <= ready ? '0 : nfall + (NW+1)'(ras_d & ~ras_n);
    end
  end

  assert_pause_quiet_R2: assert property (@(posedge clk) disable iff (rst || rst_d)
    (quiet_cnt < TW'(PAUSE_CYC)) |-> (ras_n && cas_n));

  assert_wake_count_R3: assert property (@(posedge clk) disable iff (rst || rst_d)
    $rose(ready) |-> (nfall == (NW+1)'(NWAKE)));

  assert_cas_leads_R5: assert property (@(posedge clk) disable iff (rst || rst_d)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  assert_ras_release_first_R5: assert property (@(posedge clk) disable iff (rst || rst_d)
    $rose(cas_n) |-> (ras_n && $past(ras_n)));

  assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (rst || rst_d)
    ready |-> (ras_n && cas_n && !busy));

  assert_idle_limit_R8: assert property (@(posedge clk) disable iff (rst || rst_d)
    ready |-> (rdy_run < TW'(IDLE_CYC)));
endmodule

// File: tb/test_dram_wake_seq.sv
`timescale 1ns/1ps
module test_dram_wake_seq;
  localparam int unsigned CLK_HZ = 1_000_000, PAUSE_US = 200, IDLE_US = 3000;
  localparam int unsigned NWAKE = 8, T_ACT = 4, T_PRE = 3;
  localparam int PAUSE_CYC = (CLK_HZ / 1000 * PAUSE_US + 999) / 1000;
  localparam int IDLE_CYC  = (CLK_HZ / 1000 * IDLE_US + 999) / 1000;

  logic clk = 1'b0, rst = 1'b1, cbr_mode = 1'b0;
  logic ras_n, cas_n, busy, ready;
  always #2.5 clk = ~clk;

  dram_wake_seq #(.CLK_HZ(CLK_HZ), .PAUSE_US(PAUSE_US), .IDLE_US(IDLE_US),
                  .NWAKE(NWAKE), .T_ACT(T_ACT), .T_PRE(T_PRE))
    i_dram_wake_seq (.clk(clk), .rst(rst), .cbr_mode(cbr_mode),
                     .ras_n(ras_n), .cas_n(cas_n), .busy(busy), .ready(ready));

  typedef struct { logic [3:0] v; int len; string tag; } seg_t;
  seg_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // value order: {ras_n, cas_n, busy, ready}
  task automatic push(input logic [3:0] v, input int len, input string tag);
    seg_t s; s.v = v; s.len = len; s.tag = tag; q.push_back(s);
  endtask

  task automatic push_cycles(input bit cbr, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      if (cbr) begin
        push(4'b1010, 1, {tag, " R5"});
        push(4'b0010, T_ACT, {tag, " R5"});
        push(4'b1010, 1, {tag, " R5"});
      end else
        push(4'b0110, T_ACT, {tag, " R4"});
      push(4'b1110, T_PRE, (i == NWAKE - 1) ? {tag, " R3"} : tag);
    end
  endtask

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: %s", tag, msg); end
  endtask

  task automatic do_reset;
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check({ras_n, cas_n, busy, ready} == 4'b1110, "R1",
          $sformatf("reset outputs actual %b expected 1110", {ras_n, cas_n, busy, ready}));
    @(posedge clk); #1 rst = 1'b0;
  endtask

  task automatic wait_empty;
    while (q.size() != 0) @(posedge clk);
  endtask

  // Monitor: run-length encode outputs and compare against the queue
  initial begin : monitor
    logic [3:0] cur;
    int len;
    bit have;
    have = 0; len = 0; cur = '0;
    forever begin
      @(negedge clk);
      if (rst) have = 0;
      else if (have && {ras_n, cas_n, busy, ready} == cur) len++;
      else begin
        if (have) begin
          if (q.size() == 0)
            check(0, "R3", $sformatf("unexpected segment actual %b x%0d expected none", cur, len));
          else begin
            seg_t e;
            e = q.pop_front();
            check(cur == e.v && len == e.len, e.tag,
                  $sformatf("segment actual %b x%0d expected %b x%0d", cur, len, e.v, e.len));
          end
        end
        cur = {ras_n, cas_n, busy, ready};
        len = 1; have = 1;
      end
    end
  end

  initial begin : watchdog
    repeat (150_000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // Row-only power-up, then idle re-burst with no pause
    cbr_mode = 1'b0;
    do_reset;
    push(4'b1110, PAUSE_CYC, "R2 R7");
    push_cycles(0, NWAKE, "R4");
    push(4'b1101, IDLE_CYC, "R8 R7");
    push_cycles(0, NWAKE, "R8");
    wait_empty;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(ready && !busy, "R7", $sformatf("ready/busy actual %b%b expected 10", ready, busy));

    // Column-first power-up, mode flipped mid-burst, re-burst uses new mode
    cbr_mode = 1'b1;
    do_reset;
    push(4'b1110, PAUSE_CYC, "R2");
    push_cycles(1, NWAKE, "R6");
    push(4'b1101, IDLE_CYC, "R8");
    push_cycles(0, NWAKE, "R6 R8");
    repeat (PAUSE_CYC + 10) @(posedge clk);
    #1 cbr_mode = 1'b0;
    wait_empty;
    repeat (3) @(posedge clk);

    // Reset in the middle of a burst restarts the full pause
    cbr_mode = 1'b1;
    do_reset;
    push(4'b1110, PAUSE_CYC, "R2");
    push_cycles(1, 3, "R9");
    push(4'b1010, 1, "R9");
    wait_empty;
    @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    push(4'b1110, PAUSE_CYC, "R9");
    push_cycles(1, NWAKE, "R9");
    wait_empty;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(ready && !busy && ras_n && cas_n, "R9",
          $sformatf("after re-init actual %b expected 1101", {ras_n, cas_n, busy, ready}));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule